// File: doc/BRIEF.md
# Sequential Restoring Divider with Overflow Detection

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock, by the restoring method. Signed operands are first turned into magnitudes. A left-shifting register then holds the partial remainder in its upper half and collects quotient bits in its lower half. A subtractor one bit wider than the divisor makes each trial. When the run ends, the signs are put back on the results.

The first of the N+1 iterations does not shift the register. It tests whether the upper half of the dividend is already at least the divisor. If so, the quotient cannot fit in N bits, and the same test catches a zero divisor. The other N iterations each produce one quotient bit.

A caller pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o`. At that point the remainder is on the high result and the quotient is on the low result. An error flag marks results that are not meaningful.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `err_o` are 0 and both result outputs are zero.
- R2: In unsigned mode (`signed_i`=0) with no error, `res_lo_o` is the truncated quotient and `res_hi_o` is the remainder. The remainder is less than the divisor and dividend = quotient*divisor + remainder.
- R3: In unsigned mode, `err_o` is 1 exactly when the dividend is at least the divisor times 2^N. This includes every zero divisor.
- R4: In signed mode (`signed_i`=1), the dividend is read as a 2N-bit two's complement value and the divisor as an N-bit two's complement value. The quotient truncates toward zero, so it is negative when the operand signs differ. A non-zero remainder has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R5: In signed mode, `err_o` is 1 exactly when the divisor is zero or the true quotient lies outside the N-bit two's complement range.
- R6: `done_o` rises exactly N+1 clock edges after the edge that accepts `start_i`. `busy_o` is 1 from the accepting edge until `done_o` rises, and `busy_o` is 0 while `done_o` is 1.
- R7: `done_o` stays high for exactly one cycle per accepted operation.
- R8: A `start_i` asserted while `busy_o` is 1 is ignored. The running operation finishes on time with its own results, and no extra `done_o` follows.
- R9: `res_hi_o`, `res_lo_o` and `err_o` change only in a cycle in which `done_o` is 1. Otherwise they hold their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when the block is idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 2N | Dividend, captured on the accepting edge |
| divisor_i | input | N | Divisor, captured on the accepting edge |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| err_o | output | 1 | Quotient overflow or zero divisor for the last operation |
| res_hi_o | output | N | Remainder of the last operation |
| res_lo_o | output | N | Quotient of the last operation |

## Verification
The checker assumes that operands and mode matter only on the edge that accepts `start_i`. It also assumes that reset is not applied in the middle of an operation, because its latency counter and captured divisor start at acceptance. The bench therefore changes operands only at a new start or while the block is busy, where the change must be ignored. It issues one-cycle start pulses and never pulses reset after the initial release. Random operands are built so that most operations stay in range, with the upper dividend half taken modulo the divisor in unsigned mode. Directed cases cover the exact overflow boundaries, zero divisors and the most negative signed quotient.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_cond_neg.sv
// Two's complement negation of a value when neg_i is set.
module div_cond_neg #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);
  always_comb begin
    if (neg_i) val_o = ~val_i + W'(1);
    else       val_o = val_i;
  end
endmodule

// File: rtl/div_step.sv
// One restoring iteration: trial subtraction, then keep or restore.
module div_step #(
  parameter int N = 32
) (
  input  logic [N:0]   part_i,
  input  logic [N-1:0] dvs_i,
  output logic         qbit_o,
  output logic [N-1:0] rest_o
);
  logic [N+1:0] trial;

  always_comb begin
    trial  = {1'b0, part_i} - {2'b00, dvs_i};
    qbit_o = ~trial[N+1];
    // a negative trial puts the partial remainder back unchanged
    rest_o = qbit_o ? trial[N-1:0] : part_i[N-1:0];
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [2*N-1:0] dividend_i,
  input  logic [N-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [N-1:0]   res_hi_o,
  output logic [N-1:0]   res_lo_o
);
  localparam int DW = 2 * N;
  localparam int CW = $clog2(N + 1);

  div_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rem_q, rem_d;
  logic [N-1:0]  dvs_q, dvs_d;
  logic          sgn_q, sgn_d;
  logic          negq_q, negq_d;
  logic          negr_q, negr_d;
  logic          ovf_q, ovf_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [N-1:0]  hi_q, hi_d;
  logic [N-1:0]  lo_q, lo_d;

  logic          dd_neg, dv_neg;
  logic [DW-1:0] dd_mag;
  logic [N-1:0]  dv_mag;
  logic          first, last;
  logic [N:0]    part;
  logic          step_q;
  logic [N-1:0]  step_rest;
  logic [DW-1:0] rem_step;
  logic [N-1:0]  quo_fix, rem_fix;
  logic          range_err;

  // operand magnitudes
  assign dd_neg = signed_i & dividend_i[DW-1];
  assign dv_neg = signed_i & divisor_i[N-1];

  div_cond_neg #(.W(DW)) u_dd_mag (.val_i(dividend_i), .neg_i(dd_neg), .val_o(dd_mag));
  div_cond_neg #(.W(N))  u_dv_mag (.val_i(divisor_i),  .neg_i(dv_neg), .val_o(dv_mag));

  // iteration datapath
  assign first = (cnt_q == '0);
  assign last  = (cnt_q == CW'(N));
  assign part  = first ? {1'b0, rem_q[DW-1:N]} : rem_q[DW-1:N-1];

  div_step #(.N(N)) u_step (
    .part_i (part),
    .dvs_i  (dvs_q),
    .qbit_o (step_q),
    .rest_o (step_rest)
  );

  // the leading pass only tests for overflow, it does not shift
  assign rem_step = first ? {step_rest, rem_q[N-1:0]}
                          : {step_rest, rem_q[N-2:0], step_q};

  // sign restoration
  div_cond_neg #(.W(N)) u_q_fix (.val_i(rem_step[N-1:0]),  .neg_i(negq_q), .val_o(quo_fix));
  div_cond_neg #(.W(N)) u_r_fix (.val_i(rem_step[DW-1:N]), .neg_i(negr_q), .val_o(rem_fix));

  // signed quotient magnitude must fit: 2^(N-1) allowed only when negative
  assign range_err = sgn_q & rem_step[N-1] & (~negq_q | (|rem_step[N-2:0]));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    sgn_d   = sgn_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    err_d   = err_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    case (state_q)
      DIV_IDLE: begin
        if (start_i) begin
          state_d = DIV_RUN;
          cnt_d   = '0;
          rem_d   = dd_mag;
          dvs_d   = dv_mag;
          sgn_d   = signed_i;
          negq_d  = dd_neg ^ dv_neg;
          negr_d  = dd_neg;
          ovf_d   = 1'b0;
        end
      end
      DIV_RUN: begin
        rem_d = rem_step;
        cnt_d = cnt_q + 1'b1;
        if (first) ovf_d = step_q;
        if (last) begin
          state_d = DIV_IDLE;
          done_d  = 1'b1;
          err_d   = ovf_q | range_err;
          hi_d    = rem_fix;
          lo_d    = quo_fix;
        end
      end
      default: state_d = DIV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      sgn_q   <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      dvs_q   <= dvs_d;
      sgn_q   <= sgn_d;
      negq_q  <= negq_d;
      negr_q  <= negr_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
      err_q   <= err_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign busy_o   = (state_q == DIV_RUN);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign res_hi_o = hi_q;
  assign res_lo_o = lo_q;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         signed_i,
  input logic         dd_sign_i,
  input logic [N-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [N-1:0] res_hi_o,
  input logic [N-1:0] res_lo_o
);
  localparam int CW = $clog2(N + 2);

  logic [CW-1:0] cyc_q;
  logic          cap_zero, cap_sgn, cap_ddsgn;
  logic [N-1:0]  cap_dvmag;
  logic [N-1:0]  dv_mag, rem_mag;

  assign dv_mag  = (signed_i && divisor_i[N-1]) ? (~divisor_i + N'(1)) : divisor_i;
  assign rem_mag = (cap_sgn && cap_ddsgn) ? (~res_hi_o + N'(1)) : res_hi_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      cap_zero  <= 1'b0;
      cap_sgn   <= 1'b0;
      cap_ddsgn <= 1'b0;
      cap_dvmag <= '0;
    end else if (start_i && !busy_o) begin
      cyc_q     <= '0;
      cap_zero  <= (divisor_i == '0);
      cap_sgn   <= signed_i;
      cap_ddsgn <= signed_i & dd_sign_i;
      cap_dvmag <= dv_mag;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q == CW'(N + 1))); // R6 R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_zero) |-> err_o); // R3 R5
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (rem_mag < cap_dvmag)); // R2
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && cap_sgn && (res_hi_o != '0)) |-> (res_hi_o[N-1] == cap_ddsgn)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(err_o))); // R9
endmodule

bind seq_divider div_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .dd_sign_i (dividend_i[2*N-1]),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .res_hi_o  (res_hi_o),
  .res_lo_o  (res_lo_o)
);

// File: tb/tb_seq_divider.sv
module tb_seq_divider;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         signed_i;
  logic [63:0]  dividend_i;
  logic [31:0]  divisor_i;
  logic         busy_o, done_o, err_o;
  logic [31:0]  res_hi_o, res_lo_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  seq_divider #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [63:0] dd, input logic [31:0] dv, input bit sg,
                                  output bit e, output logic [31:0] q, output logic [31:0] r);
    logic [63:0] mdd, mdv, qm, rm, lim;
    bit sdd, sdv, neg;
    sdd = sg & dd[63];
    sdv = sg & dv[31];
    mdd = sdd ? -dd : dd;
    mdv = sdv ? -{{32{dv[31]}}, dv} : {32'd0, dv};
    neg = sdd ^ sdv;
    q = '0; r = '0; e = 1'b0;
    if (mdv == 0) begin
      e = 1'b1;
      return;
    end
    qm = mdd / mdv;
    rm = mdd % mdv;
    if (sg) lim = neg ? 64'h8000_0000 : 64'h7FFF_FFFF;
    else    lim = 64'hFFFF_FFFF;
    e = (qm > lim);
    q = neg ? 32'(-qm) : qm[31:0];
    r = sdd ? 32'(-rm) : rm[31:0];
  endfunction

  task automatic do_op(input logic [63:0] dd, input logic [31:0] dv, input bit sg, input bit inject);
    int  lat;
    bit  e;
    logic [31:0] q, r;
    string rq_v, rq_e;
    ref_div(dd, dv, sg, e, q, r);
    rq_v = sg ? "R4" : "R2";
    rq_e = sg ? "R5" : "R3";
    @(negedge clk);
    start_i = 1'b1; signed_i = sg; dividend_i = dd; divisor_i = dv;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 60) begin
      if (lat > 0) chk(busy_o, "R6 busy during run", 64'(busy_o), 64'd1);
      @(negedge clk);
      lat++;
      if (inject && lat == 5) begin
        start_i = 1'b1; signed_i = ~sg; dividend_i = ~dd; divisor_i = dv + 32'd7;
      end else if (inject && lat == 6) begin
        start_i = 1'b0;
      end
    end
    chk(lat == N + 1, inject ? "R8 latency with ignored start" : "R6 latency", 64'(lat), 64'(N + 1));
    chk(!busy_o, "R6 idle at done", 64'(busy_o), 64'd0);
    chk(err_o == e, rq_e, 64'(err_o), 64'(e));
    if (!e) begin
      chk(res_lo_o == q, {rq_v, " quotient", inject ? " R8" : ""}, 64'(res_lo_o), 64'(q));
      chk(res_hi_o == r, {rq_v, " remainder", inject ? " R8" : ""}, 64'(res_hi_o), 64'(r));
    end
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [63:0] dd;
    logic [31:0] dv, hi;
    logic [31:0] h0, l0;
    bit e0;
    int quiet;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R1 flags in reset", {61'd0, busy_o, done_o, err_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R1 flags after reset", {61'd0, busy_o, done_o, err_o}, 64'd0);
    chk(res_hi_o == 0 && res_lo_o == 0, "R1 results after reset", {res_hi_o, res_lo_o}, 64'd0);

    // unsigned directed
    do_op(64'd266, 32'd23, 1'b0, 1'b0);                       // R2
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0); // R3 overflow
    do_op(64'h1234_5678_9ABC_DEF0, 32'd0, 1'b0, 1'b0);         // R3 zero divisor
    do_op(64'd0, 32'd0, 1'b0, 1'b0);                           // R3 zero by zero
    do_op({32'd1000, 32'd0}, 32'd1000, 1'b0, 1'b0);            // R3 exact boundary
    do_op({32'd1000, 32'd0} - 64'd1, 32'd1000, 1'b0, 1'b0);    // R2 just below
    do_op(64'd5, 32'd9, 1'b0, 1'b0);                           // R2 zero quotient
    // signed directed
    do_op(-64'sd7, 32'd2, 1'b1, 1'b0);                         // R4
    do_op(64'd7, -32'sd2, 1'b1, 1'b0);                         // R4
    do_op(-64'sd7, -32'sd2, 1'b1, 1'b0);                       // R4
    do_op(-64'sd8, 32'd2, 1'b1, 1'b0);                         // R4 exact
    do_op(-64'sh8000_0000, 32'd1, 1'b1, 1'b0);                 // R5 most negative fits
    do_op(64'h8000_0000, 32'd1, 1'b1, 1'b0);                   // R5 positive overflow
    do_op(-64'sh8000_0000, -32'sd1, 1'b1, 1'b0);               // R5 overflow
    do_op(64'h8000_0000_0000_0000, -32'sd1, 1'b1, 1'b0);       // R5 min dividend
    do_op(-64'sd100, 32'd0, 1'b1, 1'b0);                       // R5 zero divisor
    do_op(64'h8000_0000_0000_0000, 32'h8000_0000, 1'b1, 1'b0); // R5 min by min

    // R8: start while busy is ignored, no extra done afterwards
    do_op(64'd123456789, 32'd97, 1'b0, 1'b1);
    quiet = 0;
    repeat (40) begin
      @(negedge clk);
      if (done_o || busy_o) quiet++;
    end
    chk(quiet == 0, "R8 no extra operation", 64'(quiet), 64'd0);

    // R9: outputs hold while inputs move without start
    h0 = res_hi_o; l0 = res_lo_o; e0 = err_o;
    repeat (10) begin
      @(negedge clk);
      dividend_i = {$urandom, $urandom}; divisor_i = $urandom; signed_i = ~signed_i;
    end
    @(negedge clk);
    chk(res_hi_o == h0 && res_lo_o == l0 && err_o == e0, "R9 results held",
        {res_hi_o, res_lo_o}, {h0, l0});

    // random unsigned
    for (int i = 0; i < 250; i++) begin
      dv = $urandom >> ($urandom % 32);
      if (dv == 0) dv = 32'd1;
      if ($urandom % 8 == 0) dd = {$urandom, $urandom};
      else begin
        hi = $urandom % dv;
        dd = {hi, $urandom};
      end
      do_op(dd, dv, 1'b0, 1'b0);
    end
    // random signed
    for (int i = 0; i < 250; i++) begin
      dd = 64'($signed({$urandom, $urandom}) >>> (8 + $urandom % 56));
      dv = 32'($signed($urandom) >>> ($urandom % 31));
      if (dv == 0) dv = 32'd3;
      do_op(dd, dv, 1'b1, 1'b0);
    end
    finish_run();
  end
endmodule